// File: doc/BRIEF.md
# Sticky Fault Status Tree

This block keeps the interrupt status of an eight-channel supply monitor. Fault inputs set flag bits that stay set until the host clears them. There are two per-channel groups, one for under-voltage and one for over-voltage, and three further groups for control/communication, self-test and vendor faults. A host reaches the flags through a byte-wide register port: a combinational read, and a single-cycle write strobe whose data bits act as write-1-to-clear requests.

Each flag is masked by its own enable input. The exceptions are a few flags that are always active. Two kinds of clear exist:

- **Condition-checked flags** clear only when their fault input has already gone low.
- **Event flags** clear on any write of 1, and the next detected event sets them again.

Read-only summary registers form an OR tree over the detail registers. An active-low interrupt output is asserted while any summary bit is 1. A double-error event also latches a failsafe status bit, which only reset removes.

There is no state machine. Every flag is a flop that moves between two named states, Idle (0) and Latched (1):

- **Set**: Idle goes to Latched when the fault input is high and the flag is enabled or always active.
- **Clear**: Latched goes to Idle on a write of 1, subject to that flag's clear rule.
- **Hold**: in every other case the flag keeps its state.

Top module: `fault_status_tree`

## Requirements
- R1: After reset, every flag and the failsafe bit are 0, every readable offset returns 0x00, and `irq_n` is 1.
- R2: Channel n (1..8) maps to bit n-1 of the under-voltage register (offset 0x02) and of the over-voltage register (offset 0x03). A flag reads 1 one clock after its fault input is high while its enable is high. A fault with the enable low leaves the flag at 0.
- R3: A set flag stays 1 after its fault input returns low.
- R4: Some flags use the condition-checked clear: the under-voltage and over-voltage flags, control bits 3 (interrupt pin) and 2 (thermal), and vendor bits 6..2 (regulator, reset mismatch, frequency, address short, address open). For these, a write of 1 clears the flag only while its fault input is low.
- R5: Other flags use the event clear: control bits 4 (register CRC) and 0 (packet error), test bits 3 (ECC single error), 2 (ECC double error), 1 (self-test complete) and 0 (self-test fail), and vendor bit 7 (startup CRC). For these, a write of 1 clears the flag even while the fault input is high.
- R6: If a flag's set condition and a write of 1 to it fall in the same cycle, the flag reads 1.
- R7: Some flags ignore their enable input: control bit 3, test bit 2 and all vendor bits. The control register is at offset 0x04, the test register at 0x05 and the vendor register at 0x06.
- R8: A test bit 2 event sets the failsafe bit, which is bit 0 of offset 0x07. The failsafe bit stays 1 until reset, whatever is written.
- R9: The monitor summary at offset 0x01 has bit 2 set to the OR of the over-voltage register and bit 0 set to the OR of the under-voltage register. All its other bits are 0.
- R10: The top summary at offset 0x00 has the following bits, each the OR of its detail register, and reads 0 in bits 6..3:
  - bit 0: the monitor summary
  - bit 1: the control register
  - bit 2: the test register
  - bit 7: the vendor register
- R11: `irq_n` is 0 exactly while some top summary bit is 1, and changes in the same cycle as the flags.
- R12: The following have no effect:
  - data bits of 0
  - writes to offsets 0x00, 0x01 and 0x07
  - writes to unmapped offsets
  - writes to reserved bits

  Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data, a 1 requests clearing that bit |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| uv_fault_i | input | NUM_CH | Live under-voltage condition per channel |
| uv_en_i | input | NUM_CH | Under-voltage flag enables |
| ov_fault_i | input | NUM_CH | Live over-voltage condition per channel |
| ov_en_i | input | NUM_CH | Over-voltage flag enables |
| ctl_fault_i | input | 8 | Control faults, aligned to control register bits |
| ctl_en_i | input | 8 | Control flag enables, same bit layout |
| test_fault_i | input | 8 | Test events, aligned to test register bits |
| test_en_i | input | 8 | Test flag enables, same bit layout |
| vend_fault_i | input | 8 | Vendor faults, aligned to vendor register bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Both per-channel registers are first walked one channel at a time. This ties each channel to its bit and to the summary and interrupt path. All 256 fault patterns with every enable high are then applied, followed by all 256 enable patterns with every fault high. These two sweeps separate a wrong OR reduction or a swapped mask from a correct one. Each clear rule is then tested with the fault input held high and the enable low. That isolates a condition-checked clear from an event clear without the set path hiding the difference. A write of 1 in the same cycle as a set checks the priority. Writes to summary, status and unmapped offsets, and writes of zero data, confirm that they change nothing.

// File: rtl/fault_tree_pkg.sv
package fault_tree_pkg;

    localparam int unsigned REG_W = 8;

    // register offsets
    localparam logic [7:0] OFS_TOP  = 8'h00;
    localparam logic [7:0] OFS_MON  = 8'h01;
    localparam logic [7:0] OFS_UV   = 8'h02;
    localparam logic [7:0] OFS_OV   = 8'h03;
    localparam logic [7:0] OFS_CTL  = 8'h04;
    localparam logic [7:0] OFS_TEST = 8'h05;
    localparam logic [7:0] OFS_VEND = 8'h06;
    localparam logic [7:0] OFS_STAT = 8'h07;

    // control group: bit4 crc, bit3 irq pin, bit2 thermal, bit0 packet error
    localparam logic [7:0] CTL_IMPL   = 8'h1D;
    localparam logic [7:0] CTL_GATED  = 8'h0C;
    localparam logic [7:0] CTL_ALWAYS = 8'h08;

    // test group: bit3 ecc single, bit2 ecc double, bit1 self-test done, bit0 self-test fail
    localparam logic [7:0] TEST_IMPL   = 8'h0F;
    localparam logic [7:0] TEST_GATED  = 8'h00;
    localparam logic [7:0] TEST_ALWAYS = 8'h04;
    localparam int unsigned TEST_DED_BIT = 2;

    // vendor group: bit7 startup crc, bits 6..2 live-condition faults
    localparam logic [7:0] VEND_IMPL  = 8'hFC;
    localparam logic [7:0] VEND_GATED = 8'h7C;

    typedef struct packed {
        logic vend;
        logic test;
        logic ctl;
        logic mon;
    } group_any_t;

endpackage

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
    parameter int unsigned     WIDTH = 8,
    parameter logic [WIDTH-1:0] IMPL  = '1,
    parameter logic [WIDTH-1:0] GATED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] live_i,
    output logic [WIDTH-1:0] flags_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (IMPL[b]) begin : g_impl
            logic clr_ok;

            if (GATED[b]) begin : g_gated
                assign clr_ok = clr_i[b] & ~live_i[b];

                // a write cannot drop a flag while its fault is still present
                assert_live_blocks_clear_R4: assert property (
                    @(posedge clk) disable iff (!rst_n)
                    (flags_o[b] && live_i[b]) |=> flags_o[b]);
            end else begin : g_event
                assign clr_ok = clr_i[b];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags_o[b] <= 1'b0;
                end else if (set_i[b]) begin
                    flags_o[b] <= 1'b1;
                end else if (clr_ok) begin
                    flags_o[b] <= 1'b0;
                end
            end

            assert_set_wins_R6: assert property (
                @(posedge clk) disable iff (!rst_n)
                set_i[b] |=> flags_o[b]);

            assert_sticky_hold_R3: assert property (
                @(posedge clk) disable iff (!rst_n)
                (flags_o[b] && !clr_i[b]) |=> flags_o[b]);

            assert_no_spurious_set_R2: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!flags_o[b] && !set_i[b]) |=> !flags_o[b]);
        end else begin : g_rsvd
            assign flags_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/fault_summary_or.sv
module fault_summary_or #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] uv_flags_i,
    input  logic [NUM_CH-1:0] ov_flags_i,
    input  logic [7:0]        ctl_flags_i,
    input  logic [7:0]        test_flags_i,
    input  logic [7:0]        vend_flags_i,
    output logic [7:0]        mon_sum_o,
    output logic [7:0]        top_sum_o,
    output logic              irq_n_o
);
    import fault_tree_pkg::*;

    group_any_t any;

    always_comb begin
        mon_sum_o    = '0;
        mon_sum_o[0] = |uv_flags_i;
        mon_sum_o[2] = |ov_flags_i;

        any.mon  = |mon_sum_o;
        any.ctl  = |ctl_flags_i;
        any.test = |test_flags_i;
        any.vend = |vend_flags_i;

        top_sum_o    = '0;
        top_sum_o[0] = any.mon;
        top_sum_o[1] = any.ctl;
        top_sum_o[2] = any.test;
        top_sum_o[7] = any.vend;

        irq_n_o = ~(|top_sum_o);
    end

endmodule

// File: rtl/fault_status_tree.sv
module fault_status_tree
    import fault_tree_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NUM_CH-1:0] uv_fault_i,
    input  logic [NUM_CH-1:0] uv_en_i,
    input  logic [NUM_CH-1:0] ov_fault_i,
    input  logic [NUM_CH-1:0] ov_en_i,
    input  logic [7:0]        ctl_fault_i,
    input  logic [7:0]        ctl_en_i,
    input  logic [7:0]        test_fault_i,
    input  logic [7:0]        test_en_i,
    input  logic [7:0]        vend_fault_i,
    output logic              irq_n
);

    localparam int unsigned CH_BITS = (NUM_CH > REG_W) ? REG_W : NUM_CH;

    logic [NUM_CH-1:0] uv_flags, ov_flags, uv_clr, ov_clr;
    logic [7:0] ctl_flags, test_flags, vend_flags;
    logic [7:0] ctl_clr, test_clr, vend_clr;
    logic [7:0] mon_sum, top_sum;
    logic       failsafe_q;

    // write strobes: data bits are clear requests for the addressed register
    always_comb begin
        uv_clr   = '0;
        ov_clr   = '0;
        ctl_clr  = '0;
        test_clr = '0;
        vend_clr = '0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_UV:   uv_clr[CH_BITS-1:0] = reg_wdata[CH_BITS-1:0];
                OFS_OV:   ov_clr[CH_BITS-1:0] = reg_wdata[CH_BITS-1:0];
                OFS_CTL:  ctl_clr  = reg_wdata;
                OFS_TEST: test_clr = reg_wdata;
                OFS_VEND: vend_clr = reg_wdata;
                default:  ;
            endcase
        end
    end

    fault_flag_bank #(.WIDTH(NUM_CH), .IMPL('1), .GATED('1)) u_uv (
        .clk(clk), .rst_n(rst_n),
        .set_i(uv_fault_i & uv_en_i), .clr_i(uv_clr),
        .live_i(uv_fault_i), .flags_o(uv_flags));

    fault_flag_bank #(.WIDTH(NUM_CH), .IMPL('1), .GATED('1)) u_ov (
        .clk(clk), .rst_n(rst_n),
        .set_i(ov_fault_i & ov_en_i), .clr_i(ov_clr),
        .live_i(ov_fault_i), .flags_o(ov_flags));

    fault_flag_bank #(.WIDTH(8), .IMPL(CTL_IMPL), .GATED(CTL_GATED)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .set_i(ctl_fault_i & (ctl_en_i | CTL_ALWAYS)), .clr_i(ctl_clr),
        .live_i(ctl_fault_i), .flags_o(ctl_flags));

    fault_flag_bank #(.WIDTH(8), .IMPL(TEST_IMPL), .GATED(TEST_GATED)) u_test (
        .clk(clk), .rst_n(rst_n),
        .set_i(test_fault_i & (test_en_i | TEST_ALWAYS)), .clr_i(test_clr),
        .live_i(test_fault_i), .flags_o(test_flags));

    fault_flag_bank #(.WIDTH(8), .IMPL(VEND_IMPL), .GATED(VEND_GATED)) u_vend (
        .clk(clk), .rst_n(rst_n),
        .set_i(vend_fault_i), .clr_i(vend_clr),
        .live_i(vend_fault_i), .flags_o(vend_flags));

    fault_summary_or #(.NUM_CH(NUM_CH)) u_sum (
        .uv_flags_i(uv_flags), .ov_flags_i(ov_flags),
        .ctl_flags_i(ctl_flags), .test_flags_i(test_flags),
        .vend_flags_i(vend_flags),
        .mon_sum_o(mon_sum), .top_sum_o(top_sum), .irq_n_o(irq_n));

    // failsafe latch: only reset releases it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            failsafe_q <= 1'b0;
        end else if (test_fault_i[TEST_DED_BIT]) begin
            failsafe_q <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_TOP:  reg_rdata = top_sum;
            OFS_MON:  reg_rdata = mon_sum;
            OFS_UV:   reg_rdata[CH_BITS-1:0] = uv_flags[CH_BITS-1:0];
            OFS_OV:   reg_rdata[CH_BITS-1:0] = ov_flags[CH_BITS-1:0];
            OFS_CTL:  reg_rdata = ctl_flags;
            OFS_TEST: reg_rdata = test_flags;
            OFS_VEND: reg_rdata = vend_flags;
            OFS_STAT: reg_rdata[0] = failsafe_q;
            default:  reg_rdata = '0;
        endcase
    end

    assert_failsafe_set_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        test_fault_i[TEST_DED_BIT] |=> failsafe_q);

    assert_failsafe_hold_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        failsafe_q |=> failsafe_q);

    assert_irq_on_channel_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|uv_flags || |ov_flags) |-> !irq_n);

    assert_irq_on_group_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|ctl_flags || |test_flags || |vend_flags) |-> !irq_n);

    assert_irq_idle_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!(|uv_flags) && !(|ov_flags) && !(|ctl_flags) && !(|test_flags)
         && !(|vend_flags)) |-> irq_n);

endmodule

// File: tb/tb_fault_status_tree.sv
`timescale 1ns/1ps
module tb_fault_status_tree;

    localparam int NUM_CH = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        reg_addr;
    logic              reg_wr;
    logic [7:0]        reg_wdata;
    logic [7:0]        reg_rdata;
    logic [NUM_CH-1:0] uv_fault_i, uv_en_i, ov_fault_i, ov_en_i;
    logic [7:0]        ctl_fault_i, ctl_en_i, test_fault_i, test_en_i, vend_fault_i;
    logic              irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fault_status_tree #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .uv_fault_i(uv_fault_i), .uv_en_i(uv_en_i),
        .ov_fault_i(ov_fault_i), .ov_en_i(ov_en_i),
        .ctl_fault_i(ctl_fault_i), .ctl_en_i(ctl_en_i),
        .test_fault_i(test_fault_i), .test_en_i(test_en_i),
        .vend_fault_i(vend_fault_i), .irq_n(irq_n));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic clear_all();
        uv_fault_i = '0; ov_fault_i = '0; ctl_fault_i = '0;
        test_fault_i = '0; vend_fault_i = '0;
        wr(8'h02, 8'hFF); wr(8'h03, 8'hFF); wr(8'h04, 8'hFF);
        wr(8'h05, 8'hFF); wr(8'h06, 8'hFF);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        uv_fault_i = '0; uv_en_i = '0; ov_fault_i = '0; ov_en_i = '0;
        ctl_fault_i = '0; ctl_en_i = '0; test_fault_i = '0; test_en_i = '0;
        vend_fault_i = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 8'(a), 8'h00);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        // R2 R9 R10 R11 walking channel, both directions
        uv_en_i = '1; ov_en_i = '1;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            uv_fault_i = NUM_CH'(1 << ch); tick(); uv_fault_i = '0;
            rd_chk("R2 uv channel bit", 8'h02, 8'(1 << ch));
            rd_chk("R9 mon summary uv", 8'h01, 8'h01);
            rd_chk("R10 top summary mon", 8'h00, 8'h01);
            check("R11 irq asserted", {7'd0, irq_n}, 8'h00);
            wr(8'h02, 8'(1 << ch));
            rd_chk("R4 uv cleared", 8'h02, 8'h00);
            check("R11 irq released", {7'd0, irq_n}, 8'h01);

            ov_fault_i = NUM_CH'(1 << ch); tick(); ov_fault_i = '0;
            rd_chk("R2 ov channel bit", 8'h03, 8'(1 << ch));
            rd_chk("R9 mon summary ov", 8'h01, 8'h04);
            wr(8'h03, 8'hFF);
            rd_chk("R4 ov cleared", 8'h03, 8'h00);
        end

        // R2 R3 fault pattern sweep, R12 zero-data write
        for (int p = 0; p < 256; p++) begin
            uv_fault_i = 8'(p); tick(); uv_fault_i = '0; tick();
            rd_chk("R3 uv pattern held", 8'h02, 8'(p));
            rd_chk("R9 mon or", 8'h01, (p != 0) ? 8'h01 : 8'h00);
            wr(8'h02, 8'h00);
            rd_chk("R12 zero write keeps", 8'h02, 8'(p));
            wr(8'h02, 8'hFF);
        end

        // R2 enable pattern sweep on over-voltage
        ov_fault_i = '1;
        for (int p = 0; p < 256; p++) begin
            ov_en_i = 8'(p); tick();
            ov_fault_i = '0;
            rd_chk("R2 ov enable mask", 8'h03, 8'(p));
            wr(8'h03, 8'hFF);
            rd_chk("R4 ov sweep clear", 8'h03, 8'h00);
            ov_fault_i = '1;
        end
        ov_fault_i = '0; ov_en_i = '1;

        // R4 live-gated clear: fault held, enable off so set cannot mask it
        uv_fault_i = 8'h04; tick();
        uv_en_i = '0;
        wr(8'h02, 8'h04);
        rd_chk("R4 uv live blocks clear", 8'h02, 8'h04);
        uv_fault_i = '0;
        wr(8'h02, 8'h04);
        rd_chk("R4 uv clear after recovery", 8'h02, 8'h00);
        uv_en_i = '1;

        ctl_en_i = 8'h1D; ctl_fault_i = 8'h04; tick();
        ctl_en_i = 8'h00;
        wr(8'h04, 8'h04);
        rd_chk("R4 thermal live blocks clear", 8'h04, 8'h04);
        ctl_fault_i = 8'h00;
        wr(8'h04, 8'h04);
        rd_chk("R4 thermal clears", 8'h04, 8'h00);

        vend_fault_i = 8'h40; tick();
        wr(8'h06, 8'h40);
        rd_chk("R4 vendor regulator held", 8'h06, 8'h40);
        vend_fault_i = 8'h00;
        wr(8'h06, 8'h40);
        rd_chk("R4 vendor regulator clears", 8'h06, 8'h00);

        // R5 event clear: fault stays high, enable off
        ctl_en_i = 8'h1D; ctl_fault_i = 8'h11; tick();
        rd_chk("R2 ctl crc and packet set", 8'h04, 8'h11);
        ctl_en_i = 8'h00;
        wr(8'h04, 8'h11);
        rd_chk("R5 crc packet clear unconditionally", 8'h04, 8'h00);
        ctl_fault_i = 8'h00;

        test_en_i = 8'h0F; test_fault_i = 8'h0B; tick();
        rd_chk("R2 test flags set", 8'h05, 8'h0B);
        rd_chk("R10 top test bit", 8'h00, 8'h04);
        test_en_i = 8'h00;
        wr(8'h05, 8'h0B);
        rd_chk("R5 test flags clear", 8'h05, 8'h00);
        test_fault_i = 8'h00;

        // R6 set wins against a same-cycle clear
        ctl_en_i = 8'h1D; ctl_fault_i = 8'h10; tick();
        wr(8'h04, 8'h10);
        rd_chk("R6 set beats clear", 8'h04, 8'h10);
        ctl_fault_i = 8'h00;
        wr(8'h04, 8'h10);
        rd_chk("R5 crc clear after event", 8'h04, 8'h00);

        // R7 always-active flags and R8 failsafe
        ctl_en_i = 8'h00; test_en_i = 8'h00;
        ctl_fault_i = 8'h1D; test_fault_i = 8'h0F; tick();
        ctl_fault_i = 8'h00; test_fault_i = 8'h00;
        rd_chk("R7 ctl only pin flag", 8'h04, 8'h08);
        rd_chk("R7 test only double flag", 8'h05, 8'h04);
        rd_chk("R8 failsafe set", 8'h07, 8'h01);
        vend_fault_i = 8'hFF; tick(); vend_fault_i = 8'h00;
        rd_chk("R7 vendor always enabled", 8'h06, 8'hFC);
        uv_fault_i = 8'h80; tick(); uv_fault_i = '0;
        rd_chk("R10 all groups", 8'h00, 8'h87);

        // R12 ignored writes
        wr(8'h00, 8'hFF);
        rd_chk("R12 summary write ignored", 8'h00, 8'h87);
        wr(8'h01, 8'hFF);
        rd_chk("R12 monitor write ignored", 8'h02, 8'h80);
        wr(8'h07, 8'hFF);
        rd_chk("R12 status write ignored", 8'h07, 8'h01);
        wr(8'h55, 8'hFF);
        rd_chk("R12 unmapped write ignored", 8'h04, 8'h08);
        rd_chk("R12 unmapped read", 8'h55, 8'h00);
        wr(8'h06, 8'h03);
        rd_chk("R12 reserved vendor bits", 8'h06, 8'hFC);

        clear_all();
        rd_chk("R10 summary empty", 8'h00, 8'h00);
        check("R11 irq released at end", {7'd0, irq_n}, 8'h01);
        rd_chk("R8 failsafe survives clears", 8'h07, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule